// File: doc/BRIEF.md
# CSR Access Legality Checker

This block sits next to the retirement port of a processor core and judges every retired CSR instruction as it goes by. From the 12-bit CSR address alone it works out whether the access is allowed: the top two address bits say whether the register may be written, and the next two bits give the least privileged mode that may touch it. A parameter list adds addresses that have no register behind them, with masks that choose in which modes, and for reads, writes or both, those addresses must fault.

If an access is illegal, the retirement must carry the trap flag. If an access is legal, it hits the one monitored CSR and does not trap, the retired destination write is compared against the CSR's reported old value and the reported new value is compared against the value the instruction should produce. The monitored CSR may be split into a low register and a high register, each at its own address and each covering its own half of the value. Each judgement appears one clock after the retirement as an error pulse with a three-bit cause.

Top module: `csr_access_checker`

## Requirements
- R1: With address bits [11:10] equal to 2'b11 the CSR is read-only, and an instruction that writes it is illegal. The values 00, 01 and 10 mark the CSR as writable.
- R2: Privilege is encoded U=2'b00, S=2'b01, M=2'b11. An access is illegal when `priv_i` is numerically below address bits [9:8].
- R3: An illegal access retired with `trap_i`=0 sets `err_kind_o[0]` (missed trap) on the next cycle. A retirement with `trap_i`=1 never raises any error bit.
- R4: The operation code `op_i` uses 001=write, 010=set, 011=clear, 101=write-immediate, 110=set-immediate and 111=clear-immediate. The set and clear forms with an `rs1_i` field of zero do not write, so they are legal on a read-only CSR.
- R5: A write or write-immediate form with `rd_i`=0 does not read. No destination check is made for it, and a read-illegal unimplemented address does not fault on it.
- R6: A legal, untrapped access to a monitored address that reads with nonzero `rd_i` must retire `ret_rd_idx_i`=`rd_i` and `ret_rd_data_i` equal to that half's old value. Any mismatch sets `err_kind_o[1]`.
- R7: On a legal, untrapped access to a monitored address, that half's new value must be `rs1_val_i` for write, old OR `rs1_val_i` for set, and old AND NOT `rs1_val_i` for clear. The immediate forms use the zero-extended 5-bit `rs1_i` field in place of `rs1_val_i`. A form that does not write must leave the old value. Any mismatch sets `err_kind_o[2]`.
- R8: The low address 0xB00 is checked against bits [XLEN-1:0] of `mon_old_i`/`mon_new_i`. The high address 0xB80 is checked against bits [2*XLEN-1:XLEN].
- R9: Two addresses have no register behind them: 0x0C5 and 0x5C0. Accesses to them are illegal when the mode is selected (U and M by default, S not selected, code 2'b10 never selected) and the access reads or writes. Both reads and writes are selected by default.
- R10: `err_o` and `err_kind_o` are registered. They are zero in reset, zero after a cycle with `ret_valid_i`=0, and zero after operation codes 000 and 100. `err_o` is high exactly when some `err_kind_o` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid_i | input | 1 | An instruction retires this cycle |
| csr_addr_i | input | 12 | CSR address of the instruction |
| priv_i | input | 2 | Privilege mode at retirement |
| op_i | input | 3 | CSR operation code (R4) |
| rd_i | input | 5 | Destination register field |
| rs1_i | input | 5 | Source register field or 5-bit immediate |
| rs1_val_i | input | XLEN | Value of the source register |
| trap_i | input | 1 | The instruction retired with a trap |
| ret_rd_idx_i | input | 5 | Retired destination register index |
| ret_rd_data_i | input | XLEN | Retired destination register data |
| mon_old_i | input | 2*XLEN | Monitored CSR value before the instruction (high half, low half) |
| mon_new_i | input | 2*XLEN | Monitored CSR value after the instruction |
| err_o | output | 1 | Error pulse for the previous retirement |
| err_kind_o | output | 3 | Cause: bit0 missed trap, bit1 bad read, bit2 bad write |

## Verification
The properties assume that the retirement inputs are stable over the whole cycle in which `ret_valid_i` is high. They also assume that none of the unimplemented addresses lies in the read-only range, so a set with a zero source at a read-only address can only be judged legal. The stimulus changes inputs only on the falling edge, one retirement per cycle. Every unimplemented address it uses has address bits [11:10] other than 2'b11. The old value given for the monitored CSR is held fixed, so the new and read-back values each case expects can be worked out by hand.

// File: rtl/csr_chk_pkg.sv
package csr_chk_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'b000,
        OP_RW   = 3'b001,
        OP_RS   = 3'b010,
        OP_RC   = 3'b011,
        OP_RSV  = 3'b100,
        OP_RWI  = 3'b101,
        OP_RSI  = 3'b110,
        OP_RCI  = 3'b111
    } csr_op_e;

    typedef enum logic [1:0] {
        FN_WRITE = 2'd0,
        FN_SET   = 2'd1,
        FN_CLEAR = 2'd2
    } csr_fn_e;

    // Packed MSB first: bit2 bad write, bit1 bad read, bit0 missed trap.
    typedef struct packed {
        logic bad_write;
        logic bad_read;
        logic missed_trap;
    } chk_kind_t;

    typedef struct packed {
        logic      err;
        chk_kind_t kind;
    } chk_state_t;

    // One bit per mode: bit0 U, bit1 S, bit2 M; reserved code maps to none.
    function automatic logic [2:0] mode_bit(input logic [1:0] priv);
        case (priv)
            2'b00:   mode_bit = 3'b001;
            2'b01:   mode_bit = 3'b010;
            2'b11:   mode_bit = 3'b100;
            default: mode_bit = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/csr_op_decode.sv
module csr_op_decode
    import csr_chk_pkg::*;
(
    input  logic [2:0] op_i,
    input  logic [4:0] rd_i,
    input  logic [4:0] rs1_i,
    output logic       is_csr_o,
    output logic       is_imm_o,
    output logic       does_read_o,
    output logic       does_write_o,
    output csr_fn_e    fn_o
);

    always_comb begin
        is_csr_o     = (op_i[1:0] != 2'b00);
        is_imm_o     = op_i[2];
        fn_o         = FN_WRITE;
        does_read_o  = 1'b0;
        does_write_o = 1'b0;
        case (op_i[1:0])
            2'b01: begin
                fn_o         = FN_WRITE;
                does_write_o = 1'b1;
                does_read_o  = (rd_i != 5'd0);
            end
            2'b10: begin
                fn_o         = FN_SET;
                does_read_o  = 1'b1;
                does_write_o = (rs1_i != 5'd0);
            end
            2'b11: begin
                fn_o         = FN_CLEAR;
                does_read_o  = 1'b1;
                does_write_o = (rs1_i != 5'd0);
            end
            default: begin
                fn_o         = FN_WRITE;
            end
        endcase
    end

endmodule

// File: rtl/csr_addr_legal.sv
module csr_addr_legal
    import csr_chk_pkg::*;
#(
    parameter int                      N_UNIMPL     = 2,
    parameter logic [N_UNIMPL*12-1:0]  UNIMPL_ADDRS = {12'h5C0, 12'h0C5},
    parameter logic [2:0]              UNIMPL_MODES = 3'b101,
    parameter bit                      UNIMPL_RD    = 1'b1,
    parameter bit                      UNIMPL_WR    = 1'b1
) (
    input  logic [11:0] addr_i,
    input  logic [1:0]  priv_i,
    input  logic        does_read_i,
    input  logic        does_write_i,
    output logic        illegal_o
);

    logic [N_UNIMPL-1:0] hit;
    logic                ro_violation;
    logic                priv_violation;
    logic                unimpl_violation;
    logic                access_selected;

    for (genvar i = 0; i < N_UNIMPL; i++) begin : g_unimpl
        assign hit[i] = (addr_i == UNIMPL_ADDRS[i*12 +: 12]);
    end

    always_comb begin
        ro_violation     = (addr_i[11:10] == 2'b11) && does_write_i;
        priv_violation   = (priv_i < addr_i[9:8]);
        access_selected  = (UNIMPL_RD && does_read_i) || (UNIMPL_WR && does_write_i);
        unimpl_violation = (|hit) && (|(mode_bit(priv_i) & UNIMPL_MODES)) && access_selected;
        illegal_o        = ro_violation || priv_violation || unimpl_violation;
    end

endmodule

// File: rtl/csr_half_check.sv
module csr_half_check
    import csr_chk_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_fn_e           fn_i,
    input  logic              does_read_i,
    input  logic              does_write_i,
    input  logic [4:0]        rd_i,
    input  logic [XLEN-1:0]   operand_i,
    input  logic [XLEN-1:0]   old_i,
    input  logic [XLEN-1:0]   new_i,
    input  logic [4:0]        ret_idx_i,
    input  logic [XLEN-1:0]   ret_data_i,
    output logic              bad_read_o,
    output logic              bad_write_o
);

    logic [XLEN-1:0] expect_new;

    always_comb begin
        expect_new = old_i;
        if (does_write_i) begin
            case (fn_i)
                FN_SET:   expect_new = old_i | operand_i;
                FN_CLEAR: expect_new = old_i & ~operand_i;
                default:  expect_new = operand_i;
            endcase
        end
        bad_write_o = (new_i != expect_new);
        bad_read_o  = does_read_i && (rd_i != 5'd0) &&
                      ((ret_idx_i != rd_i) || (ret_data_i != old_i));
    end

endmodule

// File: rtl/csr_access_checker.sv
module csr_access_checker
    import csr_chk_pkg::*;
#(
    parameter int                      XLEN         = 32,
    parameter logic [11:0]             MON_LO       = 12'hB00,
    parameter bit                      MON_HAS_HI   = 1'b1,
    parameter logic [11:0]             MON_HI       = 12'hB80,
    parameter int                      N_UNIMPL     = 2,
    parameter logic [N_UNIMPL*12-1:0]  UNIMPL_ADDRS = {12'h5C0, 12'h0C5},
    parameter logic [2:0]              UNIMPL_MODES = 3'b101,
    parameter bit                      UNIMPL_RD    = 1'b1,
    parameter bit                      UNIMPL_WR    = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ret_valid_i,
    input  logic [11:0]         csr_addr_i,
    input  logic [1:0]          priv_i,
    input  logic [2:0]          op_i,
    input  logic [4:0]          rd_i,
    input  logic [4:0]          rs1_i,
    input  logic [XLEN-1:0]     rs1_val_i,
    input  logic                trap_i,
    input  logic [4:0]          ret_rd_idx_i,
    input  logic [XLEN-1:0]     ret_rd_data_i,
    input  logic [2*XLEN-1:0]   mon_old_i,
    input  logic [2*XLEN-1:0]   mon_new_i,
    output logic                err_o,
    output logic [2:0]          err_kind_o
);

    localparam int NHALF = MON_HAS_HI ? 2 : 1;

    logic            is_csr;
    logic            is_imm;
    logic            does_read;
    logic            does_write;
    csr_fn_e         fn;
    logic            illegal;
    logic [XLEN-1:0] operand;
    logic [NHALF-1:0] half_hit;
    logic [NHALF-1:0] half_bad_rd;
    logic [NHALF-1:0] half_bad_wr;

    chk_state_t st_d, st_q;

    csr_op_decode u_dec (
        .op_i         (op_i),
        .rd_i         (rd_i),
        .rs1_i        (rs1_i),
        .is_csr_o     (is_csr),
        .is_imm_o     (is_imm),
        .does_read_o  (does_read),
        .does_write_o (does_write),
        .fn_o         (fn)
    );

    csr_addr_legal #(
        .N_UNIMPL     (N_UNIMPL),
        .UNIMPL_ADDRS (UNIMPL_ADDRS),
        .UNIMPL_MODES (UNIMPL_MODES),
        .UNIMPL_RD    (UNIMPL_RD),
        .UNIMPL_WR    (UNIMPL_WR)
    ) u_legal (
        .addr_i       (csr_addr_i),
        .priv_i       (priv_i),
        .does_read_i  (does_read),
        .does_write_i (does_write),
        .illegal_o    (illegal)
    );

    assign operand = is_imm ? XLEN'(rs1_i) : rs1_val_i;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        localparam logic [11:0] HALF_ADDR = (h == 0) ? MON_LO : MON_HI;

        assign half_hit[h] = (csr_addr_i == HALF_ADDR);

        csr_half_check #(.XLEN(XLEN)) u_half (
            .fn_i         (fn),
            .does_read_i  (does_read),
            .does_write_i (does_write),
            .rd_i         (rd_i),
            .operand_i    (operand),
            .old_i        (mon_old_i[h*XLEN +: XLEN]),
            .new_i        (mon_new_i[h*XLEN +: XLEN]),
            .ret_idx_i    (ret_rd_idx_i),
            .ret_data_i   (ret_rd_data_i),
            .bad_read_o   (half_bad_rd[h]),
            .bad_write_o  (half_bad_wr[h])
        );
    end

    if (!MON_HAS_HI) begin : g_no_hi
        logic unused_hi;
        assign unused_hi = ^{mon_old_i[2*XLEN-1:XLEN], mon_new_i[2*XLEN-1:XLEN]};
    end

    always_comb begin
        st_d = '0;
        if (ret_valid_i && is_csr) begin
            st_d.kind.missed_trap = illegal && !trap_i;
            if (!illegal && !trap_i) begin
                st_d.kind.bad_read  = |(half_hit & half_bad_rd);
                st_d.kind.bad_write = |(half_hit & half_bad_wr);
            end
            st_d.err = |st_d.kind;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o      = st_q.err;
    assign err_kind_o = st_q.kind;

endmodule

// File: rtl/csr_access_checker_sva.sv
module csr_access_checker_sva #(
    parameter int          XLEN   = 32,
    parameter logic [11:0] MON_LO = 12'hB00
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ret_valid_i,
    input logic [11:0]         csr_addr_i,
    input logic [1:0]          priv_i,
    input logic [2:0]          op_i,
    input logic [4:0]          rs1_i,
    input logic [XLEN-1:0]     rs1_val_i,
    input logic                trap_i,
    input logic [2*XLEN-1:0]   mon_new_i,
    input logic                err_o,
    input logic [2:0]          err_kind_o
);

    p_ro_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid_i && !trap_i && (op_i[1:0] == 2'b01) && (csr_addr_i[11:10] == 2'b11)
        |=> err_kind_o[0]);

    p_low_priv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid_i && !trap_i && (op_i[1:0] != 2'b00) && (priv_i < csr_addr_i[9:8])
        |=> err_o && err_kind_o[0]);

    p_trap_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid_i && trap_i |=> (err_kind_o == 3'b000) && !err_o);

    // Assumes no unimplemented address lies in the read-only range.
    p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid_i && !trap_i && op_i[1] && (rs1_i == 5'd0) &&
        (csr_addr_i[11:10] == 2'b11) && (priv_i >= csr_addr_i[9:8])
        |=> !err_kind_o[0]);

    p_write_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid_i && !trap_i && (priv_i == 2'b11) && (op_i == 3'b001) &&
        (csr_addr_i == MON_LO) && (mon_new_i[XLEN-1:0] != rs1_val_i)
        |=> err_kind_o[2]);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid_i |=> !err_o && (err_kind_o == 3'b000));

    p_flag_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o == (err_kind_o != 3'b000));

endmodule

bind csr_access_checker csr_access_checker_sva #(
    .XLEN   (XLEN),
    .MON_LO (MON_LO)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .ret_valid_i (ret_valid_i),
    .csr_addr_i  (csr_addr_i),
    .priv_i      (priv_i),
    .op_i        (op_i),
    .rs1_i       (rs1_i),
    .rs1_val_i   (rs1_val_i),
    .trap_i      (trap_i),
    .mon_new_i   (mon_new_i),
    .err_o       (err_o),
    .err_kind_o  (err_kind_o)
);

// File: tb/sim_csr_access_checker.sv
`timescale 1ns/1ps
module sim_csr_access_checker;

    localparam int XLEN = 32;
    localparam logic [63:0] OLD = 64'h0000_0007_0000_00F0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ret_valid_i = 1'b0;
    logic [11:0]       csr_addr_i = '0;
    logic [1:0]        priv_i = '0;
    logic [2:0]        op_i = '0;
    logic [4:0]        rd_i = '0;
    logic [4:0]        rs1_i = '0;
    logic [XLEN-1:0]   rs1_val_i = '0;
    logic              trap_i = 1'b0;
    logic [4:0]        ret_rd_idx_i = '0;
    logic [XLEN-1:0]   ret_rd_data_i = '0;
    logic [2*XLEN-1:0] mon_old_i = '0;
    logic [2*XLEN-1:0] mon_new_i = '0;
    logic              err_o;
    logic [2:0]        err_kind_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    csr_access_checker u0 (.*);

    task automatic apply(input logic [11:0] addr, input logic [1:0] priv,
                         input logic [2:0] op, input logic [4:0] rd,
                         input logic [4:0] rs1, input logic [31:0] rs1v,
                         input logic trap, input logic [4:0] ridx,
                         input logic [31:0] rdata, input logic [63:0] nw,
                         input logic [2:0] expk, input string tag);
        @(negedge clk);
        ret_valid_i   = 1'b1;
        csr_addr_i    = addr;
        priv_i        = priv;
        op_i          = op;
        rd_i          = rd;
        rs1_i         = rs1;
        rs1_val_i     = rs1v;
        trap_i        = trap;
        ret_rd_idx_i  = ridx;
        ret_rd_data_i = rdata;
        mon_old_i     = OLD;
        mon_new_i     = nw;
        exp_q.push_back(expk);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        ret_valid_i   = 1'b0;
        csr_addr_i    = 12'hB00;
        priv_i        = 2'b00;
        op_i          = 3'b001;
        trap_i        = 1'b0;
        exp_q.push_back(3'b000);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare one cycle after each driven retirement.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_tests++;
                if (err_kind_o !== e || err_o !== (e != 3'b000)) begin
                    n_fail++;
                    $display("FAIL %s: err_kind=%b err=%b expected kind=%b err=%b",
                             t, err_kind_o, err_o, e, (e != 3'b000));
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_tests++;
        if (err_o !== 1'b0 || err_kind_o !== 3'b000) begin
            n_fail++;
            $display("FAIL R10 reset: err=%b kind=%b expected err=0 kind=000", err_o, err_kind_o);
        end

        // Legal reads and writes of the low half
        apply(12'hB00, 2'b11, 3'b010, 5'd5, 5'd3, 32'h0F, 0, 5'd5, 32'hF0, {32'h7, 32'hFF}, 3'b000, "R6 R7 set ok");
        apply(12'hB00, 2'b11, 3'b010, 5'd5, 5'd3, 32'h0F, 0, 5'd5, 32'hF1, {32'h7, 32'hFF}, 3'b010, "R6 bad read data");
        apply(12'hB00, 2'b11, 3'b010, 5'd5, 5'd3, 32'h0F, 0, 5'd6, 32'hF0, {32'h7, 32'hFF}, 3'b010, "R6 bad read index");
        apply(12'hB00, 2'b11, 3'b011, 5'd5, 5'd4, 32'h30, 0, 5'd5, 32'hF0, {32'h7, 32'hC1}, 3'b100, "R7 clear wrong new");
        apply(12'hB00, 2'b11, 3'b011, 5'd5, 5'd4, 32'h30, 0, 5'd5, 32'hF0, {32'h7, 32'hC0}, 3'b000, "R7 clear ok");
        apply(12'hB00, 2'b11, 3'b001, 5'd0, 5'd2, 32'h1234, 0, 5'd9, 32'hDEAD, {32'h7, 32'h1234}, 3'b000, "R5 R7 write rd0 no read");
        apply(12'hB00, 2'b11, 3'b110, 5'd0, 5'h0A, 32'hFFFF_FFFF, 0, 5'd0, 32'h0, {32'h7, 32'hFA}, 3'b000, "R7 set-imm ok");
        apply(12'hB00, 2'b11, 3'b101, 5'd0, 5'h1F, 32'hFFFF_FFFF, 0, 5'd0, 32'h0, {32'h7, 32'hFFFF_FFFF}, 3'b100, "R7 write-imm used reg");
        apply(12'hB00, 2'b11, 3'b010, 5'd1, 5'd0, 32'h55, 0, 5'd1, 32'hF0, {32'h7, 32'hF5}, 3'b100, "R7 no-write changed");
        // High half
        apply(12'hB80, 2'b11, 3'b001, 5'd2, 5'd6, 32'hAAAA, 0, 5'd2, 32'h7, {32'hAAAA, 32'hF0}, 3'b000, "R8 high write ok");
        apply(12'hB80, 2'b11, 3'b001, 5'd2, 5'd6, 32'hAAAA, 0, 5'd2, 32'hF0, {32'hAAAA, 32'hF0}, 3'b010, "R8 high read got low");
        apply(12'hB80, 2'b11, 3'b011, 5'd0, 5'd6, 32'h2, 0, 5'd0, 32'h0, {32'h5, 32'hF0}, 3'b000, "R8 high clear ok");
        // Privilege and traps
        apply(12'hB00, 2'b01, 3'b010, 5'd3, 5'd0, 32'h0, 0, 5'd3, 32'hF0, OLD, 3'b001, "R2 S reads M csr");
        apply(12'hB00, 2'b01, 3'b010, 5'd3, 5'd0, 32'h0, 1, 5'd0, 32'h0, OLD, 3'b000, "R3 trapped ok");
        apply(12'hB00, 2'b11, 3'b010, 5'd3, 5'd0, 32'h0, 1, 5'd4, 32'h1, OLD, 3'b000, "R3 trap suppresses value check");
        apply(12'h100, 2'b00, 3'b001, 5'd1, 5'd1, 32'h1, 0, 5'd1, 32'h0, OLD, 3'b001, "R2 U writes S csr");
        apply(12'h100, 2'b01, 3'b001, 5'd1, 5'd1, 32'h1, 0, 5'd1, 32'h0, OLD, 3'b000, "R2 S writes S csr");
        // Read-only range
        apply(12'hC00, 2'b11, 3'b001, 5'd4, 5'd1, 32'h1, 0, 5'd4, 32'h0, OLD, 3'b001, "R1 write read-only");
        apply(12'hC00, 2'b11, 3'b010, 5'd4, 5'd0, 32'h9, 0, 5'd4, 32'h0, OLD, 3'b000, "R4 set x0 on read-only");
        apply(12'hC00, 2'b00, 3'b111, 5'd4, 5'd0, 32'h9, 0, 5'd4, 32'h0, OLD, 3'b000, "R4 clear-imm zero on read-only");
        apply(12'hC00, 2'b00, 3'b110, 5'd4, 5'd1, 32'h0, 0, 5'd4, 32'h0, OLD, 3'b001, "R4 set-imm nonzero on read-only");
        // Unimplemented addresses
        apply(12'h0C5, 2'b00, 3'b010, 5'd1, 5'd0, 32'h0, 0, 5'd1, 32'h0, OLD, 3'b001, "R9 U reads unimpl");
        apply(12'h0C5, 2'b11, 3'b001, 5'd1, 5'd1, 32'h3, 0, 5'd1, 32'h0, OLD, 3'b001, "R9 M writes unimpl");
        apply(12'h0C5, 2'b01, 3'b001, 5'd1, 5'd1, 32'h3, 0, 5'd1, 32'h0, OLD, 3'b000, "R9 S not selected");
        apply(12'h0C5, 2'b10, 3'b001, 5'd1, 5'd1, 32'h3, 0, 5'd1, 32'h0, OLD, 3'b000, "R9 reserved mode not selected");
        apply(12'h5C0, 2'b11, 3'b001, 5'd0, 5'd1, 32'h3, 0, 5'd0, 32'h0, OLD, 3'b001, "R9 M write-only unimpl");
        apply(12'h5C0, 2'b11, 3'b001, 5'd0, 5'd1, 32'h3, 1, 5'd0, 32'h0, OLD, 3'b000, "R9 R3 unimpl trapped");
        apply(12'h5C0, 2'b01, 3'b010, 5'd2, 5'd0, 32'h0, 0, 5'd2, 32'h0, OLD, 3'b000, "R9 S unimpl not selected");
        // Non-CSR codes and idle
        apply(12'hB00, 2'b00, 3'b000, 5'd1, 5'd1, 32'h1, 0, 5'd7, 32'h1, 64'h0, 3'b000, "R10 op 000 ignored");
        apply(12'hB00, 2'b00, 3'b100, 5'd1, 5'd1, 32'h1, 0, 5'd7, 32'h1, 64'h0, 3'b000, "R10 op 100 ignored");
        idle("R10 idle cycle");
        apply(12'h300, 2'b11, 3'b001, 5'd3, 5'd3, 32'h1, 0, 5'd9, 32'h1, 64'h0, 3'b000, "R6 unmonitored not compared");
        idle("R10 idle after");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule